// File: doc/BRIEF.md
# Pipelined Pseudo-Mersenne Modular Multiply-Accumulate

This block is the arithmetic core of one residue channel. On every clock it can take two r-bit operands and fold their product, plus an optional running sum, into a fully reduced residue modulo m = 2^r − c. Here c is a small constant below 2^q, and q < r/2.

Reduction needs no divider. The high half of the product is multiplied by c and added back to the low half. This is done twice: once through an r×q multiplier and once through a q×q multiplier. A short chain of modular adders then brings the value into range.

The work is split over six register stages, so one operation can enter every cycle. The last stage holds the running result. When the accumulate control is high, that result is added back in. When it is low, zero is added instead, which starts a new sum.

Top module: `pmod_mac`

## Requirements
- R1: Every result presented with `out_valid` high lies in the range [0, m), where m = 2^R_W − C_K.
- R2: An operation issued with `acc_en` low yields (op_a·op_b) mod m for any operands below 2^R_W.
- R3: An operation issued with `acc_en` high yields (prev + op_a·op_b) mod m. Here prev is the result of the most recent earlier valid operation.
- R4: A valid operation sampled on a rising edge appears on `result` with `out_valid` high after the sixth rising edge, counting the sampling edge. A new operation may enter on every cycle, and results leave in issue order.
- R5: With `acc_en` low, the earlier result has no effect on the new result, even inside a run of accumulating operations.
- R6: Cycles with `in_valid` low produce no output. During them `out_valid` is low and `result` keeps its value. An accumulation chain resumes across such gaps from the last valid result.
- R7: Synchronous active-high reset clears `out_valid` and sets `result` to 0. The first operation after reset with `acc_en` high therefore yields op_a·op_b mod m.
- R8: Operands equal to or above m are handled: 0, 1, m−1, m and 2^R_W−1 all reduce correctly, both in every pairing and in a chain of accumulations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and control are valid this cycle |
| acc_en | input | 1 | 1: add the previous result; 0: add zero |
| op_a | input | R_W | First multiplicand |
| op_b | input | R_W | Second multiplicand |
| out_valid | output | 1 | `result` holds a newly completed operation |
| result | output | R_W | Reduced residue, also the running accumulator |

## Verification
The assertions assume that the parameters satisfy 2·Q_W < R_W and C_K < 2^Q_W. Under these conditions each intermediate sum stays inside the adder widths, and the second fold is already below m. They also assume that `rst` is held high from time zero until the first rising edge, so that every valid bit starts cleared.

The stimulus uses only operands below 2^R_W, including the values at and above m. It holds `in_valid` low throughout reset. Bubbles and back-to-back issue are mixed, so that at most six operations are ever in flight.

// File: rtl/pmod_mac.sv
module pmod_mac #(
  parameter int R_W = 17,
  parameter int Q_W = 4,
  parameter int C_K = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           acc_en,
  input  logic [R_W-1:0] op_a,
  input  logic [R_W-1:0] op_b,
  output logic           out_valid,
  output logic [R_W-1:0] result
);

  localparam int          PW  = 2 * R_W;
  localparam int          QPW = R_W + Q_W;
  localparam logic [R_W:0] MOD = {1'b1, {R_W{1'b0}}} - (R_W+1)'(C_K);
  localparam logic [Q_W-1:0] CK = Q_W'(C_K);

  // both inputs below m: one conditional subtraction suffices
  function automatic logic [R_W-1:0] add_lt(input logic [R_W-1:0] a, input logic [R_W-1:0] b);
    logic [R_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MOD) s = s - MOD;
    return s[R_W-1:0];
  endfunction

  // first input below m, second up to 2^r - 1: up to two subtractions
  function automatic logic [R_W-1:0] add_wide(input logic [R_W-1:0] a, input logic [R_W-1:0] b);
    logic [R_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MOD) s = s - MOD;
    if (s >= MOD) s = s - MOD;
    return s[R_W-1:0];
  endfunction

  // stage 1: operand capture
  logic           v1, e1;
  logic [R_W-1:0] a1, b1;
  // stage 2: full product
  logic           v2, e2;
  logic [PW-1:0]  p2;
  // stage 3: first fold and reduced low half
  logic           v3, e3;
  logic [QPW-1:0] q3;
  logic [R_W-1:0] rl3;
  // stage 4: second fold and partial sum
  logic           v4, e4;
  logic [R_W-1:0] rq4, s4;
  // stage 5: reduced product
  logic           v5, e5;
  logic [R_W-1:0] t5;

  logic [R_W-1:0]   p_lo, p_hi, q_lo;
  logic [Q_W-1:0]   q_hi;
  logic [2*Q_W-1:0] rq_n;

  assign p_lo = p2[R_W-1:0];
  assign p_hi = p2[PW-1:R_W];
  assign q_lo = q3[R_W-1:0];
  assign q_hi = q3[QPW-1:R_W];
  assign rq_n = {{Q_W{1'b0}}, q_hi} * {{Q_W{1'b0}}, CK};

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0; v5 <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
      v5 <= v4;
      out_valid <= v5;
      if (v5) result <= add_lt(t5, e5 ? result : '0);
    end
  end

  always_ff @(posedge clk) begin
    a1  <= op_a;
    b1  <= op_b;
    e1  <= acc_en;
    p2  <= {{R_W{1'b0}}, a1} * {{R_W{1'b0}}, b1};
    e2  <= e1;
    q3  <= {{Q_W{1'b0}}, p_hi} * {{R_W{1'b0}}, CK};
    rl3 <= ({1'b0, p_lo} >= MOD) ? R_W'({1'b0, p_lo} - MOD) : p_lo;
    e3  <= e2;
    rq4 <= {{(R_W-2*Q_W){1'b0}}, rq_n};
    s4  <= add_wide(rl3, q_lo);
    e4  <= e3;
    t5  <= add_lt(rq4, s4);
    e5  <= e4;
  end

  // occupancy counter used only by the latency assertion
  logic [3:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + 4'(in_valid) - 4'(out_valid);
  end

  a_r1_result_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, result} < MOD));

  a_r1_fold_in_range: assert property (@(posedge clk) disable iff (rst)
    v4 |-> (({1'b0, s4} < MOD) && ({1'b0, rq4} < MOD)));

  a_r1_reduced_product: assert property (@(posedge clk) disable iff (rst)
    v5 |-> ({1'b0, t5} < MOD));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(result));

  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    inflight <= 4'd6);

  a_r7_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0));

endmodule

// File: tb/tb_pmod_mac.sv
module tb_pmod_mac;
  localparam int R_W = 17;
  localparam int Q_W = 4;
  localparam int C_K = 9;
  localparam longint MODV = (longint'(1) << R_W) - C_K;
  localparam longint TOPV = (longint'(1) << R_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic acc_en = 1'b0;
  logic [R_W-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [R_W-1:0] result;

  pmod_mac #(.R_W(R_W), .Q_W(Q_W), .C_K(C_K)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_en(acc_en),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result));

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  longint model = 0;
  longint exp_val [0:4095];
  int     exp_cyc [0:4095];
  string  exp_tag [0:4095];
  int wr = 0, rd = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd == wr) chk(0, "R6 unexpected out_valid", 1, 0);
      else begin
        chk(longint'(result) == exp_val[rd], exp_tag[rd], longint'(result), exp_val[rd]);
        chk(longint'(result) < MODV, "R1 range", longint'(result), MODV - 1);
        chk(cyc - exp_cyc[rd] == 6, "R4 latency", cyc - exp_cyc[rd], 6);
        rd++;
      end
    end
  end

  task automatic issue(input longint a, input longint b, input bit acc, input string tag);
    longint pr;
    @(negedge clk);
    op_a = R_W'(a); op_b = R_W'(b); acc_en = acc; in_valid = 1'b1;
    pr = (a * b) % MODV;
    model = acc ? (model + pr) % MODV : pr;
    exp_val[wr] = model; exp_cyc[wr] = cyc; exp_tag[wr] = tag;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (rd != wr) @(negedge clk);
    idle(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    chk(result == '0, "R7 result in reset", result, 0);
    rst = 1'b0; model = 0;
    idle(2);
    chk(result == '0, "R7 result after reset", result, 0);
  endtask

  task automatic t_basic();
    issue(3, 5, 0, "R2 small");
    issue(1000, 2000, 0, "R2 mid");
    issue(65536, 65536, 0, "R2 power of two");
    issue(123, 0, 0, "R2 zero operand");
    drain();
  endtask

  task automatic t_boundary();
    longint v [5];
    v[0] = 0; v[1] = 1; v[2] = MODV - 1; v[3] = MODV; v[4] = TOPV;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        issue(v[i], v[j], 0, "R8 boundary pair");
    for (int i = 0; i < 6; i++) issue(TOPV, TOPV - i, 1, "R8 boundary chain");
    drain();
  endtask

  task automatic t_accum();
    issue(7, 9, 0, "R3 chain start");
    for (int i = 1; i < 12; i++) issue(1000 * i + 17, 997 * i, 1, "R3 chain");
    drain();
  endtask

  task automatic t_clear();
    issue(MODV - 1, MODV - 1, 0, "R5 pre");
    issue(TOPV, 12345, 1, "R5 pre acc");
    issue(2, 3, 0, "R5 clear mid chain");
    issue(4, 5, 1, "R5 acc after clear");
    drain();
  endtask

  task automatic t_bubbles();
    logic [R_W-1:0] held;
    issue(111, 222, 0, "R6 chain start");
    idle(3);
    issue(333, 444, 1, "R6 acc across gap");
    idle(1);
    issue(555, 666, 1, "R6 acc across gap");
    drain();
    held = result;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 no output when idle", out_valid, 0);
      chk(result == held, "R6 result holds", result, held);
    end
  endtask

  task automatic t_random();
    longint a, b;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = longint'(lfsr[R_W-1:0]);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = longint'(lfsr[R_W-1:0]);
      if (lfsr[20:18] == 3'd0) idle(1);
      issue(a, b, lfsr[23], "R3 random");
    end
    drain();
  endtask

  task automatic t_acc_after_reset();
    t_reset();
    issue(4321, 8765, 1, "R7 first acc after reset");
    drain();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_boundary();
    t_accum();
    t_clear();
    t_bubbles();
    t_random();
    t_acc_after_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wr - rd, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule